// File: doc/BRIEF.md
# Interrupt Destination Mask Generator

This block takes one interrupt message and works out which of N processor-local interrupt units should receive it. The result is an N-bit target mask. A message holds an 8-bit destination, a bit that picks physical or logical addressing, a 2-bit shorthand code and the index of the unit that sent it. Every unit presents three values: its 8-bit physical ID, its 8-bit logical destination and its 4-bit format model. The format model says whether the unit takes part in flat or in cluster logical addressing.

A valid strobe captures the message. One clock cycle later the registered mask appears, together with a mask-valid flag. For messages that use lowest-priority delivery, the block also reports one chosen target: the set bit of the mask with the lowest index. Choosing among units by priority value, and carrying the message to the units, are jobs for other blocks.

Top module: `irq_dest_mask_gen`

## Requirements
- R1: After reset, `maskValid`, `selValid` and `targetMask` are all zero.
- R2: A message sampled with `msgValid` high at a clock edge produces `targetMask` and `maskValid` = 1 after that edge. A cycle without `msgValid` drives `maskValid` and `selValid` to 0 and leaves `targetMask` unchanged.
- R3: With shorthand 0 and `msgLogical` = 0, a destination other than 8'hFF selects exactly the units whose physical ID equals it. If no unit has that ID, the mask is zero.
- R4: With shorthand 0 and `msgLogical` = 0, destination 8'hFF selects every unit.
- R5: With shorthand 0 and `msgLogical` = 1, a unit whose format model is 4'hF (flat) is selected when the bitwise AND of the destination and its logical destination is nonzero.
- R6: With shorthand 0 and `msgLogical` = 1, a unit whose format model is 4'h0 (cluster) is selected only when both of these hold: bits 7:4 of the destination equal bits 7:4 of its logical destination, and bits 3:0 of the two values AND to a nonzero value.
- R7: In logical mode, a unit whose format model is neither 4'hF nor 4'h0 is never selected.
- R8: Shorthand codes 1, 2 and 3 override the destination and the mode bit. Code 1 selects only the sender, code 2 selects every unit, and code 3 selects every unit except the sender.
- R9: When `msgLowPri` is set and the mask is nonzero, `selValid` is 1 alongside `maskValid`, and `selIdx` is the lowest index whose mask bit is set. In every other case `selValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| msgValid | input | 1 | Message strobe |
| msgDest | input | 8 | Destination field |
| msgLogical | input | 1 | 0 = physical addressing, 1 = logical addressing |
| msgShort | input | 2 | Shorthand: 0 destination, 1 self, 2 all, 3 all but self |
| msgSender | input | IDX_W | Index of the sending unit |
| msgLowPri | input | 1 | Lowest-priority delivery requested |
| unitPhysId | input | NUM_UNITS*8 | Physical IDs; unit u at bits [u*8 +: 8] |
| unitLogDest | input | NUM_UNITS*8 | Logical destinations; unit u at bits [u*8 +: 8] |
| unitModel | input | NUM_UNITS*4 | Format models; unit u at bits [u*4 +: 4] |
| maskValid | output | 1 | targetMask holds the result of the last message |
| targetMask | output | NUM_UNITS | Delivery mask, one bit per unit |
| selValid | output | 1 | selIdx is valid |
| selIdx | output | IDX_W | Chosen target for lowest-priority delivery |

## Verification
The mask is registered, so a wrong addressing decision for any unit appears as a wrong bit in `targetMask` in the cycle right after the message is captured. It can be traced to that message alone. If the selection logic picks the wrong unit, `selIdx` points either at a clear mask bit or above a lower set bit, and this is also visible in the same cycle. Fault in the capture control show at the ports in two ways: `maskValid` leaving the strobe pattern, or the mask changing during an idle cycle. Both can be seen one cycle after the cause.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;

  typedef enum logic [1:0] {
    SH_DEST     = 2'd0,
    SH_SELF     = 2'd1,
    SH_ALL      = 2'd2,
    SH_ALL_OTHR = 2'd3
  } shorthand_e;

  localparam logic [3:0] MODEL_FLAT    = 4'hF;
  localparam logic [3:0] MODEL_CLUSTER = 4'h0;
  localparam logic [7:0] DEST_BCAST    = 8'hFF;

  typedef struct packed {
    logic load;
    logic lowPri;
  } dest_strobe_t;

endpackage

// File: rtl/irq_dest_ctrl.sv
module irq_dest_ctrl
  import irq_dest_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         msgValid,
  input  logic         msgLowPri,
  output dest_strobe_t strobe,
  output logic         maskValid
);

  always_comb begin
    strobe.load   = msgValid;
    strobe.lowPri = msgLowPri;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskValid <= 1'b0;
    else       maskValid <= msgValid;
  end

endmodule

// File: rtl/irq_dest_datapath.sv
module irq_dest_datapath
  import irq_dest_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int IDX_W     = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dest_strobe_t           strobe,
  input  logic [7:0]             msgDest,
  input  logic                   msgLogical,
  input  logic [1:0]             msgShort,
  input  logic [IDX_W-1:0]       msgSender,
  input  logic [NUM_UNITS*8-1:0] unitPhysId,
  input  logic [NUM_UNITS*8-1:0] unitLogDest,
  input  logic [NUM_UNITS*4-1:0] unitModel,
  output logic [NUM_UNITS-1:0]   targetMask,
  output logic                   selValid,
  output logic [IDX_W-1:0]       selIdx
);

  logic [NUM_UNITS-1:0] addrMatch;
  logic [NUM_UNITS-1:0] isSender;
  logic [NUM_UNITS-1:0] nextMask;
  logic [IDX_W-1:0]     lowIdx;
  logic                 anyHit;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic [7:0] pid;
    logic [7:0] ldest;
    logic [3:0] model;
    logic       physHit;
    logic       flatHit;
    logic       clusHit;

    assign pid     = unitPhysId[u*8 +: 8];
    assign ldest   = unitLogDest[u*8 +: 8];
    assign model   = unitModel[u*4 +: 4];
    assign physHit = (msgDest == DEST_BCAST) || (msgDest == pid);
    assign flatHit = (model == MODEL_FLAT) && (|(msgDest & ldest));
    assign clusHit = (model == MODEL_CLUSTER) &&
                     (msgDest[7:4] == ldest[7:4]) &&
                     (|(msgDest[3:0] & ldest[3:0]));
    assign addrMatch[u] = msgLogical ? (flatHit || clusHit) : physHit;
    assign isSender[u]  = (msgSender == IDX_W'(u));
  end

  always_comb begin
    unique case (shorthand_e'(msgShort))
      SH_DEST:     nextMask = addrMatch;
      SH_SELF:     nextMask = isSender;
      SH_ALL:      nextMask = '1;
      SH_ALL_OTHR: nextMask = ~isSender;
      default:     nextMask = '0;
    endcase
  end

  always_comb begin
    lowIdx = '0;
    for (int i = NUM_UNITS - 1; i >= 0; i--) begin
      if (nextMask[i]) lowIdx = IDX_W'(i);
    end
    anyHit = |nextMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      targetMask <= '0;
      selValid   <= 1'b0;
      selIdx     <= '0;
    end else if (strobe.load) begin
      targetMask <= nextMask;
      selValid   <= strobe.lowPri && anyHit;
      selIdx     <= lowIdx;
    end else begin
      selValid   <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_dest_mask_gen.sv
module irq_dest_mask_gen
  import irq_dest_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int IDX_W     = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   msgValid,
  input  logic [7:0]             msgDest,
  input  logic                   msgLogical,
  input  logic [1:0]             msgShort,
  input  logic [IDX_W-1:0]       msgSender,
  input  logic                   msgLowPri,
  input  logic [NUM_UNITS*8-1:0] unitPhysId,
  input  logic [NUM_UNITS*8-1:0] unitLogDest,
  input  logic [NUM_UNITS*4-1:0] unitModel,
  output logic                   maskValid,
  output logic [NUM_UNITS-1:0]   targetMask,
  output logic                   selValid,
  output logic [IDX_W-1:0]       selIdx
);

  dest_strobe_t strobe;

  irq_dest_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .msgValid  (msgValid),
    .msgLowPri (msgLowPri),
    .strobe    (strobe),
    .maskValid (maskValid)
  );

  irq_dest_datapath #(
    .NUM_UNITS (NUM_UNITS),
    .IDX_W     (IDX_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .msgDest     (msgDest),
    .msgLogical  (msgLogical),
    .msgShort    (msgShort),
    .msgSender   (msgSender),
    .unitPhysId  (unitPhysId),
    .unitLogDest (unitLogDest),
    .unitModel   (unitModel),
    .targetMask  (targetMask),
    .selValid    (selValid),
    .selIdx      (selIdx)
  );

endmodule

// File: rtl/irq_dest_mask_chk.sv
module irq_dest_mask_chk #(
  parameter int NUM_UNITS = 8,
  parameter int IDX_W     = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 msgValid,
  input logic [7:0]           msgDest,
  input logic                 msgLogical,
  input logic [1:0]           msgShort,
  input logic [IDX_W-1:0]     msgSender,
  input logic                 maskValid,
  input logic [NUM_UNITS-1:0] targetMask,
  input logic                 selValid,
  input logic [IDX_W-1:0]     selIdx
);

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |=> maskValid);

  // R2
  idle_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    !msgValid |=> (!maskValid && !selValid));

  // R2
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    !msgValid |=> $stable(targetMask));

  // R4
  phys_bcast_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgShort == 2'd0 && !msgLogical && msgDest == 8'hFF)
      |=> (&targetMask));

  // R8
  short_self_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgShort == 2'd1) |=> $onehot0(targetMask));

  // R8
  short_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgShort == 2'd2) |=> (&targetMask));

  // R8
  short_others_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgShort == 2'd3 && int'(msgSender) < NUM_UNITS)
      |=> ($countones(targetMask) == NUM_UNITS - 1));

  // R9
  sel_in_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    selValid |-> (maskValid && targetMask[selIdx]));

  // R9
  sel_lowest_chk: assert property (@(posedge clk) disable iff (!rstN)
    selValid |-> ((targetMask & ((NUM_UNITS'(1) << selIdx) - NUM_UNITS'(1))) == '0));

endmodule

bind irq_dest_mask_gen irq_dest_mask_chk #(
  .NUM_UNITS (NUM_UNITS),
  .IDX_W     (IDX_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .msgValid   (msgValid),
  .msgDest    (msgDest),
  .msgLogical (msgLogical),
  .msgShort   (msgShort),
  .msgSender  (msgSender),
  .maskValid  (maskValid),
  .targetMask (targetMask),
  .selValid   (selValid),
  .selIdx     (selIdx)
);

// File: tb/irq_dest_mask_gen_tb.sv
`timescale 1ns/1ps
module irq_dest_mask_gen_tb;

  localparam int N  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          msgValid = 1'b0;
  logic [7:0]    msgDest = '0;
  logic          msgLogical = 1'b0;
  logic [1:0]    msgShort = '0;
  logic [IW-1:0] msgSender = '0;
  logic          msgLowPri = 1'b0;
  logic [N*8-1:0] unitPhysId;
  logic [N*8-1:0] unitLogDest;
  logic [N*4-1:0] unitModel;
  logic          maskValid;
  logic [N-1:0]  targetMask;
  logic          selValid;
  logic [IW-1:0] selIdx;

  int checkCount = 0;
  int passCount  = 0;

  typedef struct packed {
    logic [N-1:0]  mask;
    logic          selV;
    logic [IW-1:0] idx;
  } exp_t;

  exp_t  expQ[$];
  string reqQ[$];

  logic [7:0] pidArr [N];
  logic [7:0] ldArr  [N];
  logic [3:0] modArr [N];

  always #2.5 clk = ~clk;

  irq_dest_mask_gen #(.NUM_UNITS(N)) u_dut (
    .clk(clk), .rstN(rstN), .msgValid(msgValid), .msgDest(msgDest),
    .msgLogical(msgLogical), .msgShort(msgShort), .msgSender(msgSender),
    .msgLowPri(msgLowPri), .unitPhysId(unitPhysId), .unitLogDest(unitLogDest),
    .unitModel(unitModel), .maskValid(maskValid), .targetMask(targetMask),
    .selValid(selValid), .selIdx(selIdx)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (ok) passCount++;
    else $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
  endtask

  function automatic logic [N-1:0] refMask(input logic [7:0] d, input logic lg,
                                           input logic [1:0] sh, input int snd);
    logic [N-1:0] m;
    m = '0;
    for (int u = 0; u < N; u++) begin
      case (sh)
        2'd0: begin
          if (!lg) m[u] = (d == 8'hFF) || (d == pidArr[u]);
          else if (modArr[u] == 4'hF) m[u] = (d & ldArr[u]) != 0;
          else if (modArr[u] == 4'h0)
            m[u] = (d[7:4] == ldArr[u][7:4]) && ((d[3:0] & ldArr[u][3:0]) != 0);
          else m[u] = 1'b0;
        end
        2'd1: m[u] = (u == snd);
        2'd2: m[u] = 1'b1;
        default: m[u] = (u != snd);
      endcase
    end
    return m;
  endfunction

  task automatic sendMsg(input logic [7:0] d, input logic lg, input logic [1:0] sh,
                         input int snd, input logic lp, input string req);
    exp_t e;
    logic [N-1:0] m;
    @(negedge clk);
    msgValid = 1'b1; msgDest = d; msgLogical = lg; msgShort = sh;
    msgSender = IW'(snd); msgLowPri = lp;
    m = refMask(d, lg, sh, snd);
    e.mask = m;
    e.selV = lp && (m != 0);
    e.idx  = '0;
    for (int i = N - 1; i >= 0; i--) if (m[i]) e.idx = IW'(i);
    expQ.push_back(e);
    reqQ.push_back(req);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && maskValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2", "unexpected maskValid", 32'(maskValid), 32'd0);
      end else begin
        exp_t  e;
        string r;
        e = expQ.pop_front();
        r = reqQ.pop_front();
        check(targetMask == e.mask, r, "targetMask", 32'(targetMask), 32'(e.mask));
        check(selValid == e.selV, {r, "/R9"}, "selValid", 32'(selValid), 32'(e.selV));
        if (e.selV)
          check(selIdx == e.idx, "R9", "selIdx", 32'(selIdx), 32'(e.idx));
      end
    end
  end

  initial begin
    #2_000_000;
    check(1'b0, "watchdog", "timeout", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", passCount, checkCount);
    $finish;
  end

  initial begin
    for (int u = 0; u < N; u++) begin
      pidArr[u] = 8'h10 + 8'(u);
      if (u < 4)      begin ldArr[u] = 8'(1 << u); modArr[u] = 4'hF; end
      else if (u == 4) begin ldArr[u] = 8'h21; modArr[u] = 4'h0; end
      else if (u == 5) begin ldArr[u] = 8'h22; modArr[u] = 4'h0; end
      else if (u == 6) begin ldArr[u] = 8'h34; modArr[u] = 4'h0; end
      else             begin ldArr[u] = 8'hFF; modArr[u] = 4'h5; end
      unitPhysId[u*8 +: 8]  = pidArr[u];
      unitLogDest[u*8 +: 8] = ldArr[u];
      unitModel[u*4 +: 4]   = modArr[u];
    end

    repeat (3) @(negedge clk);
    // R1 reset state
    check(maskValid == 1'b0, "R1", "maskValid", 32'(maskValid), 32'd0);
    check(selValid == 1'b0, "R1", "selValid", 32'(selValid), 32'd0);
    check(targetMask == '0, "R1", "targetMask", 32'(targetMask), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    sendMsg(8'h13, 1'b0, 2'd0, 0, 1'b0, "R3");      // single physical hit
    sendMsg(8'h55, 1'b0, 2'd0, 0, 1'b1, "R3");      // no unit: zero mask, no selection
    sendMsg(8'hFF, 1'b0, 2'd0, 0, 1'b0, "R4");      // broadcast
    sendMsg(8'h05, 1'b1, 2'd0, 0, 1'b1, "R5");      // flat units 0 and 2
    sendMsg(8'h23, 1'b1, 2'd0, 0, 1'b1, "R5/R6");   // flat and cluster together
    sendMsg(8'h30, 1'b1, 2'd0, 0, 1'b0, "R6");      // cluster match, empty low nibble
    sendMsg(8'h34, 1'b1, 2'd0, 0, 1'b1, "R6");      // cluster unit 6, flat unit 2
    sendMsg(8'hFF, 1'b1, 2'd0, 0, 1'b0, "R7");      // model 5 unit excluded
    sendMsg(8'h13, 1'b0, 2'd1, 5, 1'b1, "R8");      // self only
    sendMsg(8'h00, 1'b1, 2'd2, 3, 1'b0, "R8");      // all
    sendMsg(8'h13, 1'b0, 2'd3, 0, 1'b1, "R8");      // all but sender 0
    sendMsg(8'h01, 1'b1, 2'd3, 7, 1'b1, "R8");      // all but sender 7

    @(negedge clk);
    msgValid = 1'b0;
    msgDest = 8'hFF; msgShort = 2'd2;
    @(negedge clk);
    @(negedge clk);
    // R2 idle: flags low, last mask held
    check(maskValid == 1'b0, "R2", "idle maskValid", 32'(maskValid), 32'd0);
    check(selValid == 1'b0, "R2", "idle selValid", 32'(selValid), 32'd0);
    check(targetMask == 8'h7F, "R2", "idle targetMask", 32'(targetMask), 32'h7F);
    check(expQ.size() == 0, "R2", "results outstanding", 32'(expQ.size()), 32'd0);

    $display("%0d/%0d checks passed", passCount, checkCount);
    $finish;
  end

endmodule